// File: doc/BRIEF.md
# Data-Space Address Generation Unit

This unit forms the effective data address for every load and store of a small 8-bit processor core. A request names an addressing mode, a pointer, an optional 6-bit offset, a full 16-bit address for absolute accesses, and, for stores, the data byte. The unit resolves the address from one of three 16-bit pointers kept in the upper six general registers. It updates the pointer when the mode asks for auto-modify. It decodes the address into one of four regions of a single linear data map and performs the byte access there.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` falls for exactly one cycle after an SRAM access is taken, and a request held during that cycle is neither taken nor answered. The response side has no back-pressure: `rsp_valid` pulses for one cycle per taken request, and the consumer must take it then. The register file, both I/O windows and the SRAM are modelled as one internal byte array, so pointers can be read and written through ordinary absolute accesses.

Top module: `dspace_agu`

## Requirements
- R1: Address regions are: 0x0000–0x001F general registers, 0x0020–0x005F standard I/O, 0x0060–0x00FF extended I/O, 0x0100 upward SRAM. `rsp_region` is one-hot with bit 0 = registers, bit 1 = standard I/O, bit 2 = extended I/O, bit 3 = SRAM.
- R2: The SRAM top is 0x00FF + `SRAM_BYTES` (0x08FF by default). A higher address completes as an out-of-range access. It raises `rsp_oor` with `rsp_region` = 0, the write is discarded, and the read returns 0x00.
- R3: Pointer X is held in registers 26 (low byte) and 27 (high byte), Y in 28/29 and Z in 30/31. `req_ptr` code 0 selects X, 1 selects Y, and 2 or 3 select Z.
- R4: Mode code 0 (absolute) uses `req_addr` unchanged as the effective address and leaves all pointers unchanged.
- R5: Mode code 1 (indirect) uses the selected pointer as the address and leaves it unchanged. Codes 5–7 behave the same way.
- R6: Mode code 2 (offset) uses pointer + zero-extended `req_disp` (0–63) and leaves the pointer unchanged. With X selected, the offset is ignored.
- R7: Mode code 3 (pre-decrement) decrements the pointer modulo 2^16, uses the new value as the address, and writes it back.
- R8: Mode code 4 (post-increment) uses the old pointer value as the address, then writes back that value + 1 modulo 2^16.
- R9: A taken access to registers, I/O or an out-of-range address gives `rsp_valid` in the next cycle with `busy` staying low. Any pointer write-back takes effect at that same edge. If the data write and the write-back hit the same register, the write-back wins.
- R10: A taken SRAM access holds `busy` high for exactly one cycle. The access, the pointer write-back and `rsp_valid` follow one cycle later.
- R11: `req_ready` is the inverse of `busy`. It is high after reset with `rsp_valid` low. A request presented while `busy` is high has no effect and gives no response.
- R12: `rsp_addr` returns the effective address. `rsp_rdata` returns the stored byte for a read and 0x00 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 2 | Pointer select |
| req_disp | input | 6 | Unsigned offset for offset mode |
| req_addr | input | 16 | Absolute address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 8 | Store data |
| busy | output | 1 | SRAM access in its first cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 8 | Load data |
| rsp_addr | output | 16 | Effective address of the access |
| rsp_region | output | 4 | One-hot region of the access |
| rsp_oor | output | 1 | Access beyond SRAM top |

## Verification
The bench drives pointers across the wrap points 0xFFFF→0x0000 and back. A unit that failed to wrap or used the wrong value as the address would point outside the map or return the wrong byte. It places accesses on every region edge, including the last SRAM byte and the first byte beyond it. An off-by-one decoder would show the wrong region bit or accept a store that must be discarded. It uses offset mode with X and with the largest offset, checking that the base pointer is left intact. It also presents a store during the stall cycle, which a unit that ignored its own busy state would commit and answer.

// File: rtl/dagu_pkg.sv
package dagu_pkg;
  localparam logic [2:0] AM_ABS     = 3'd0;
  localparam logic [2:0] AM_IND     = 3'd1;
  localparam logic [2:0] AM_OFS     = 3'd2;
  localparam logic [2:0] AM_PREDEC  = 3'd3;
  localparam logic [2:0] AM_POSTINC = 3'd4;

  localparam int PTR_BASE = 26;
  localparam int NREGION  = 4;

  typedef enum logic [1:0] {
    RG_GPR   = 2'd0,
    RG_STDIO = 2'd1,
    RG_EXTIO = 2'd2,
    RG_SRAM  = 2'd3
  } region_e;

  function automatic logic [1:0] ptr_norm(input logic [1:0] sel);
    return (sel == 2'd3) ? 2'd2 : sel;
  endfunction
endpackage

// File: rtl/dagu_ea.sv
module dagu_ea
  import dagu_pkg::*;
(
  input  logic [2:0]  mode,
  input  logic [1:0]  psel,
  input  logic [5:0]  disp,
  input  logic [15:0] abs_addr,
  input  logic [15:0] ptr_val,
  output logic [15:0] ea,
  output logic [15:0] ptr_next,
  output logic        ptr_upd
);
  always_comb begin
    ea       = ptr_val;
    ptr_next = ptr_val;
    ptr_upd  = 1'b0;
    case (mode)
      AM_ABS: ea = abs_addr;
      AM_OFS: ea = ptr_val + ((ptr_norm(psel) == 2'd0) ? 16'd0 : {10'd0, disp});
      AM_PREDEC: begin
        ptr_next = ptr_val - 16'd1;
        ea       = ptr_next;
        ptr_upd  = 1'b1;
      end
      AM_POSTINC: begin
        ptr_next = ptr_val + 16'd1;
        ptr_upd  = 1'b1;
      end
      default: ea = ptr_val;
    endcase
  end
endmodule

// File: rtl/dagu_region.sv
module dagu_region
  import dagu_pkg::*;
#(
  parameter int SRAM_BYTES = 2048
) (
  input  logic [15:0]        addr,
  output logic [NREGION-1:0] sel,
  output logic               oor
);
  localparam int TOP = 255 + SRAM_BYTES;
  localparam logic [31:0] TOP32 = 32'(TOP);

  region_e rg;

  always_comb begin
    if (addr < 16'h0020)      rg = RG_GPR;
    else if (addr < 16'h0060) rg = RG_STDIO;
    else if (addr < 16'h0100) rg = RG_EXTIO;
    else                      rg = RG_SRAM;
    oor = {16'd0, addr} > TOP32;
  end

  for (genvar i = 0; i < NREGION; i++) begin : g_sel
    assign sel[i] = !oor && (rg == region_e'(i));
  end
endmodule

// File: rtl/dagu_store.sv
module dagu_store
  import dagu_pkg::*;
#(
  parameter int DEPTH = 2304,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic          pwe,
  input  logic [1:0]    pwsel,
  input  logic [15:0]   pwval,
  input  logic [1:0]    prsel,
  output logic [15:0]   prval
);
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] pw_lo, pr_lo;

  always_comb begin
    pw_lo = AW'(PTR_BASE + 2 * int'(ptr_norm(pwsel)));
    pr_lo = AW'(PTR_BASE + 2 * int'(ptr_norm(prsel)));
  end

  assign rdata = mem[raddr];
  assign prval = {mem[pr_lo + AW'(1)], mem[pr_lo]};

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (pwe) begin
      mem[pw_lo]         <= pwval[7:0];
      mem[pw_lo + AW'(1)] <= pwval[15:8];
    end
  end
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
  import dagu_pkg::*;
#(
  parameter int SRAM_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_mode,
  input  logic [1:0]  req_ptr,
  input  logic [5:0]  req_disp,
  input  logic [15:0] req_addr,
  input  logic        req_write,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic [15:0] rsp_addr,
  output logic [3:0]  rsp_region,
  output logic        rsp_oor
);
  localparam int DEPTH = 256 + SRAM_BYTES;
  localparam int AW    = $clog2(DEPTH);

  logic [15:0] ptr_val, ea, ptr_next;
  logic        ptr_upd;
  logic [NREGION-1:0] sel_now;
  logic        oor_now;
  logic        busy_q, accept, to_sram, fast;

  logic [15:0] st_addr, st_pnext;
  logic        st_write, st_upd;
  logic [7:0]  st_wdata;
  logic [1:0]  st_ptr;

  logic [15:0] acc_addr, pw_val;
  logic        mem_we, pwe;
  logic [1:0]  pw_sel;
  logic [7:0]  mem_wdata, mem_rdata;

  dagu_ea u_ea (
    .mode(req_mode), .psel(req_ptr), .disp(req_disp), .abs_addr(req_addr),
    .ptr_val(ptr_val), .ea(ea), .ptr_next(ptr_next), .ptr_upd(ptr_upd)
  );

  dagu_region #(.SRAM_BYTES(SRAM_BYTES)) u_region (
    .addr(ea), .sel(sel_now), .oor(oor_now)
  );

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign accept    = req_valid && !busy_q;
  assign to_sram   = sel_now[RG_SRAM];
  assign fast      = accept && !to_sram;

  always_comb begin
    if (busy_q) begin
      acc_addr  = st_addr;
      mem_we    = st_write;
      mem_wdata = st_wdata;
      pwe       = st_upd;
      pw_sel    = st_ptr;
      pw_val    = st_pnext;
    end else begin
      acc_addr  = ea;
      mem_we    = fast && req_write && !oor_now;
      mem_wdata = req_wdata;
      pwe       = fast && ptr_upd;
      pw_sel    = req_ptr;
      pw_val    = ptr_next;
    end
  end

  dagu_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(mem_we), .waddr(acc_addr[AW-1:0]), .wdata(mem_wdata),
    .raddr(acc_addr[AW-1:0]), .rdata(mem_rdata),
    .pwe(pwe), .pwsel(pw_sel), .pwval(pw_val),
    .prsel(req_ptr), .prval(ptr_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= 8'h00;
      rsp_addr   <= 16'h0000;
      rsp_region <= '0;
      rsp_oor    <= 1'b0;
      st_addr    <= '0;
      st_pnext   <= '0;
      st_write   <= 1'b0;
      st_upd     <= 1'b0;
      st_wdata   <= '0;
      st_ptr     <= '0;
    end else begin
      busy_q    <= accept && to_sram;
      rsp_valid <= fast || busy_q;
      if (busy_q) begin
        rsp_rdata  <= st_write ? 8'h00 : mem_rdata;
        rsp_addr   <= st_addr;
        rsp_region <= 4'(1 << RG_SRAM);
        rsp_oor    <= 1'b0;
      end else if (fast) begin
        rsp_rdata  <= (req_write || oor_now) ? 8'h00 : mem_rdata;
        rsp_addr   <= ea;
        rsp_region <= sel_now;
        rsp_oor    <= oor_now;
      end
      if (accept && to_sram) begin
        st_addr  <= ea;
        st_pnext <= ptr_next;
        st_write <= req_write;
        st_upd   <= ptr_upd;
        st_wdata <= req_wdata;
        st_ptr   <= req_ptr;
      end
    end
  end

  // R10
  busy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R10
  sram_rsp_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rsp_valid && rsp_region == 4'b1000));
  // R9
  fast_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !sel_now[RG_SRAM]) |=> (rsp_valid && !busy));
  // R1
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($onehot0(rsp_region) && (rsp_oor == (rsp_region == 4'b0000))));
  // R2
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_oor) |-> (rsp_rdata == 8'h00));
  // R11
  stall_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> (rsp_valid && !busy));
endmodule

// File: tb/sim_dspace_agu.sv
module sim_dspace_agu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready, busy, rsp_valid, rsp_oor;
  logic [2:0] req_mode = '0;
  logic [1:0] req_ptr = '0;
  logic [5:0] req_disp = '0;
  logic [15:0] req_addr = '0, rsp_addr;
  logic [7:0] req_wdata = '0, rsp_rdata;
  logic [3:0] rsp_region;

  always #2 clk = ~clk;

  dspace_agu u0 (.*);

  typedef struct {
    logic [7:0]  rd;
    logic [15:0] a;
    logic [3:0]  sel;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;

  localparam logic [3:0] GPR = 4'b0001, SIO = 4'b0010, EIO = 4'b0100, SRM = 4'b1000, NONE = 4'b0000;
  localparam logic [2:0] ABS = 3'd0, IND = 3'd1, OFS = 3'd2, PRE = 3'd3, PST = 4'd4;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // driver: called at a falling edge, returns at a falling edge
  task automatic issue(input logic [2:0] m, input logic [1:0] p, input logic [5:0] d,
                       input logic [15:0] a, input logic w, input logic [7:0] wd,
                       input logic [7:0] erd, input logic [15:0] ea,
                       input logic [3:0] esel, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_ptr = p; req_disp = d;
    req_addr = a; req_write = w; req_wdata = wd;
    e.rd = erd; e.a = ea; e.sel = esel; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    // R9 / R10: stall only for SRAM, fast response otherwise
    chk({tag, " busy(R9/R10)"}, {31'd0, busy}, {31'd0, esel[3]});
    chk({tag, " rsp timing(R9/R10)"}, {31'd0, rsp_valid}, {31'd0, !esel[3]});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v, input logic [3:0] s, input string tag);
    issue(ABS, 2'd0, 6'd0, a, 1'b1, v, 8'h00, a, s, tag);
  endtask
  task automatic rd(input logic [15:0] a, input logic [7:0] v, input logic [3:0] s, input string tag);
    issue(ABS, 2'd0, 6'd0, a, 1'b0, 8'h00, v, a, s, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: unexpected response addr %h expected none", rsp_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " rdata"}, {24'd0, rsp_rdata}, {24'd0, e.rd});
        chk({e.tag, " addr(R12)"}, {16'd0, rsp_addr}, {16'd0, e.a});
        chk({e.tag, " region(R1)"}, {28'd0, rsp_region}, {28'd0, e.sel});
        chk({e.tag, " oor(R2)"}, {31'd0, rsp_oor}, {31'd0, e.sel == 4'b0000});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // R3 set X=0x0100, Y=0x0210, Z=0xFFFF through absolute stores
    wr(16'h001A, 8'h00, GPR, "R3"); wr(16'h001B, 8'h01, GPR, "R3");
    wr(16'h001C, 8'h10, GPR, "R3"); wr(16'h001D, 8'h02, GPR, "R3");
    wr(16'h001E, 8'hFF, GPR, "R3"); wr(16'h001F, 8'hFF, GPR, "R3");

    // R8 post-increment store via X
    issue(PST, 2'd0, 6'd0, 16'h0, 1'b1, 8'hA5, 8'h00, 16'h0100, SRM, "R8 X+ store");
    rd(16'h001A, 8'h01, GPR, "R8 X low"); rd(16'h001B, 8'h01, GPR, "R8 X high");
    // R7 pre-decrement load via X
    issue(PRE, 2'd0, 6'd0, 16'h0, 1'b0, 8'h00, 8'hA5, 16'h0100, SRM, "R7 -X load");
    rd(16'h001A, 8'h00, GPR, "R7 X low");
    // R6 offset 63 on Y
    issue(OFS, 2'd1, 6'd63, 16'h0, 1'b1, 8'h3C, 8'h00, 16'h024F, SRM, "R6 Y+63 store");
    rd(16'h001C, 8'h10, GPR, "R6 Y unchanged");
    rd(16'h024F, 8'h3C, SRM, "R4 absolute read");
    // R6 offset ignored with X
    issue(OFS, 2'd0, 6'd5, 16'h0, 1'b0, 8'h00, 8'hA5, 16'h0100, SRM, "R6 X offset ignored");
    // R5 plain indirect via Y
    issue(IND, 2'd1, 6'd0, 16'h0, 1'b1, 8'h66, 8'h00, 16'h0210, SRM, "R5 Y store");
    issue(IND, 2'd1, 6'd0, 16'h0, 1'b0, 8'h00, 8'h66, 16'h0210, SRM, "R5 Y load");
    rd(16'h001D, 8'h02, GPR, "R5 Y high unchanged");
    // R8 wrap on Z, out of range
    issue(PST, 2'd2, 6'd0, 16'h0, 1'b0, 8'h00, 8'h00, 16'hFFFF, NONE, "R8 Z+ wrap");
    rd(16'h001E, 8'h00, GPR, "R8 Z low wrapped"); rd(16'h001F, 8'h00, GPR, "R8 Z high wrapped");
    // R7 wrap down, write discarded
    issue(PRE, 2'd2, 6'd0, 16'h0, 1'b1, 8'h77, 8'h00, 16'hFFFF, NONE, "R7 -Z wrap");
    rd(16'h001E, 8'hFF, GPR, "R7 Z low"); rd(16'h001F, 8'hFF, GPR, "R7 Z high");
    // R2 SRAM top boundary
    wr(16'h0900, 8'h55, NONE, "R2 store beyond top");
    rd(16'h0900, 8'h00, NONE, "R2 load beyond top");
    wr(16'h08FF, 8'h12, SRM, "R2 last byte store");
    rd(16'h08FF, 8'h12, SRM, "R2 last byte load");
    // R1 region edges
    wr(16'h0020, 8'h21, SIO, "R1"); wr(16'h005F, 8'h5F, SIO, "R1");
    wr(16'h0060, 8'h60, EIO, "R1"); wr(16'h00FF, 8'hEF, EIO, "R1");
    rd(16'h0020, 8'h21, SIO, "R1 std io first"); rd(16'h005F, 8'h5F, SIO, "R1 std io last");
    rd(16'h0060, 8'h60, EIO, "R1 ext io first"); rd(16'h00FF, 8'hEF, EIO, "R1 ext io last");
    // R3 code 3 selects Z
    wr(16'h001E, 8'h00, GPR, "R3"); wr(16'h001F, 8'h01, GPR, "R3");
    issue(IND, 2'd3, 6'd0, 16'h0, 1'b0, 8'h00, 8'hA5, 16'h0100, SRM, "R3 code3 is Z");

    // R11 request during stall is ignored
    wr(16'h0005, 8'h5A, GPR, "R11 prep");
    begin
      exp_t e;
      req_valid = 1'b1; req_mode = ABS; req_addr = 16'h0101; req_write = 1'b1; req_wdata = 8'h99;
      e.rd = 8'h00; e.a = 16'h0101; e.sel = SRM; e.tag = "R11 sram store";
      q.push_back(e);
      @(negedge clk);
      chk("R11 ready low in stall", {31'd0, req_ready}, 32'd0);
      req_addr = 16'h0005; req_wdata = 8'hEE;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
    end
    rd(16'h0005, 8'h5A, GPR, "R11 stall store ignored");
    rd(16'h0101, 8'h99, SRM, "R10 sram store landed");

    repeat (4) @(negedge clk);
    chk("R11 all responses seen", q.size(), 32'd0);
    summary();
  end
endmodule